// File: doc/BRIEF.md
# Layer Bus Demultiplexer

This block takes hit words from seven external input buses and places them onto eight internal layer buses that feed a pattern matcher. Each external word is one bit wider than an internal address. Its most significant bit is a selector bit, and the block removes that bit before it forwards the word. Each internal bus has its own output register, with a valid flag and an end-of-event flag.

The block has two routing modes, and a static configuration input picks one of them. The input is sampled only while reset is held. In shared-outer mode, external buses 0 to 5 each feed the internal bus with the same number. External bus 6 carries hits for two outer layers, and its selector bit steers each word to internal bus 6 or to internal bus 7. In inner-split mode, external bus 0 carries a double-rate inner layer. Its words alternate between internal buses 0 and 1, and both of those buses hold the same logical layer. External buses 1 to 6 then feed internal buses 2 to 7.

An end-of-event word goes to every internal bus that its external bus feeds. On the split bus it also restarts the alternation at the lower internal bus.

Top module: `layer_bus_demux`

## Requirements
- R1: While rst_n is low, every int_valid and int_eoe bit is 0, and the split alternation returns to internal bus 0.
- R2: In shared-outer mode (cfg_split sampled as 0), a non-end-of-event word on external bus 6 appears on internal bus 6 when its bit ADDR_W is 0, and on internal bus 7 when that bit is 1.
- R3: Each forwarded word has its bit ADDR_W removed, so int_addr carries ext_word bits ADDR_W-1:0. Outputs appear on the clock edge after the input is sampled.
- R4: In inner-split mode (cfg_split sampled as 1), non-end-of-event words on external bus 0 go to internal buses 0, 1, 0, 1 and so on, starting with bus 0.
- R5: Direct mapping: in shared-outer mode external bus i (0 to 5) feeds internal bus i; in inner-split mode external bus i (1 to 6) feeds internal bus i+1.
- R6: A valid word with its ext_eoe bit set goes to both internal buses of a pair (6 and 7 in shared-outer mode, 0 and 1 in inner-split mode), with int_eoe set. On the split bus, the next word then goes to internal bus 0.
- R7: An internal bus raises int_valid only for a word routed to it. With no external valid, every int_valid is 0.
- R8: A change of cfg_split after reset is released has no effect on routing until the next reset.
- R9: In inner-split mode, the bit ADDR_W of an external bus 0 word has no effect on which internal bus receives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; cfg_split is sampled while it is low |
| cfg_split | input | 1 | Mode: 0 shared-outer, 1 inner-split |
| ext_valid | input | 7 | Per external bus: word present |
| ext_eoe | input | 7 | Per external bus: word is an end-of-event marker |
| ext_word | input | 7*(ADDR_W+1) | External words, bus i at bits i*(ADDR_W+1) and up; top bit of each is the selector |
| int_valid | output | 8 | Per internal bus: registered word valid |
| int_eoe | output | 8 | Per internal bus: registered end-of-event flag |
| int_addr | output | 8*ADDR_W | Internal addresses, bus k at bits k*ADDR_W and up |

## Verification
A wrong mode latch shows at the ports one cycle after the first word, either on bus 6 or 7 or on the split pair. A stuck or skipped alternation state shows as two words in a row landing on the same split bus. A missed restart of the alternation after end-of-event shows on the first word of the next event. The bench compares every internal bus on every cycle with a model that tracks its own alternation, so any of these faults appears within one or two cycles of the word that exposes it.

// File: rtl/lbd_pkg.sv
// Shared constants and the routing-mode type for the layer bus demultiplexer.
// Assumes the fixed bus layout: one shared outer source, one split inner source.
package lbd_pkg;
    localparam int EXT_BUSES  = 7;              // external input buses
    localparam int INT_BUSES  = 8;              // internal layer buses
    localparam int SHARED_EXT = EXT_BUSES - 1;  // external bus carrying two outer layers
    localparam int SPLIT_EXT  = 0;              // external bus carrying the double-rate layer
    localparam int SPLIT_LO   = 0;              // lower internal bus of the split pair

    typedef enum logic {
        MODE_SHARED = 1'b0,
        MODE_SPLIT  = 1'b1
    } lbd_mode_e;
endpackage

// File: rtl/lbd_alt.sv
// Alternation state for the split inner bus: 0 means the next word goes to the lower bus.
// Assumes the sel output is used only in split mode; it advances only in that mode.
module lbd_alt (
    input  logic clk,
    input  logic rst_n,
    input  logic split_mode,
    input  logic in_valid,
    input  logic in_eoe,
    output logic sel
);
    // Flip on each hit word, go back to the lower bus on end-of-event or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= 1'b0;
        else if (split_mode && in_valid)
            sel <= in_eoe ? 1'b0 : ~sel;
    end
endmodule

// File: rtl/lbd_route.sv
// Combinational steering from the external buses to the next-state of each internal bus.
// Assumes the package layout; it strips the selector bit from every forwarded word.
module lbd_route
    import lbd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                          split_mode,
    input  logic                          alt_sel,
    input  logic [EXT_BUSES-1:0]          ext_valid,
    input  logic [EXT_BUSES-1:0]          ext_eoe,
    input  logic [EXT_BUSES*(ADDR_W+1)-1:0] ext_word,
    output logic [INT_BUSES-1:0]          nxt_valid,
    output logic [INT_BUSES-1:0]          nxt_eoe,
    output logic [INT_BUSES*ADDR_W-1:0]   nxt_addr
);
    localparam int W = ADDR_W + 1;

    for (genvar k = 0; k < INT_BUSES; k++) begin : g_lane
        // Source bus in each mode and whether this lane belongs to a steered pair.
        localparam int S0    = (k <= SHARED_EXT) ? k : SHARED_EXT;
        localparam int S1    = (k <= SPLIT_LO + 1) ? SPLIT_EXT : k - 1;
        localparam bit PAIR0 = (k == SHARED_EXT) || (k == SHARED_EXT + 1);
        localparam bit HI0   = (k == SHARED_EXT + 1);
        localparam bit PAIR1 = (k == SPLIT_LO) || (k == SPLIT_LO + 1);
        localparam bit HI1   = (k == SPLIT_LO + 1);

        logic [W-1:0] w0, w1;
        logic         en0, en1;

        assign w0 = ext_word[S0*W +: W];
        assign w1 = ext_word[S1*W +: W];

        // Lane enables: a pair lane takes a word when the steering matches or on end-of-event.
        always_comb begin
            en0 = ext_valid[S0] &
                  (!PAIR0 | ext_eoe[S0] | (HI0 ? w0[ADDR_W] : ~w0[ADDR_W]));
            en1 = ext_valid[S1] &
                  (!PAIR1 | ext_eoe[S1] | (HI1 ? alt_sel : ~alt_sel));
        end

        // Pick the mode's source and drop the selector bit.
        always_comb begin
            nxt_valid[k] = split_mode ? en1 : en0;
            nxt_eoe[k]   = split_mode ? ext_eoe[S1] : ext_eoe[S0];
            nxt_addr[k*ADDR_W +: ADDR_W] = split_mode ? w1[ADDR_W-1:0] : w0[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/lbd_out_reg.sv
// Output register for one internal bus: valid and end-of-event flags, plus an address that is held.
// Assumes the address matters only while valid is high.
module lbd_out_reg #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic              d_eoe,
    input  logic [ADDR_W-1:0] d_addr,
    output logic              q_valid,
    output logic              q_eoe,
    output logic [ADDR_W-1:0] q_addr
);
    // Flags follow the input each cycle and clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_eoe   <= 1'b0;
        end else begin
            q_valid <= d_valid;
            q_eoe   <= d_valid & d_eoe;
        end
    end

    // The address loads only for a routed word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_addr <= '0;
        else if (d_valid)
            q_addr <= d_addr;
    end
endmodule

// File: rtl/layer_bus_demux.sv
// Top: latches the mode during reset, steers 7 external buses onto 8 registered internal buses.
// Assumes cfg_split is stable while rst_n is low; it is ignored once reset is released.
module layer_bus_demux
    import lbd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_split,
    input  logic [EXT_BUSES-1:0]              ext_valid,
    input  logic [EXT_BUSES-1:0]              ext_eoe,
    input  logic [EXT_BUSES*(ADDR_W+1)-1:0]   ext_word,
    output logic [INT_BUSES-1:0]              int_valid,
    output logic [INT_BUSES-1:0]              int_eoe,
    output logic [INT_BUSES*ADDR_W-1:0]       int_addr
);
    lbd_mode_e                   mode_q;
    logic                        alt_sel;
    logic [INT_BUSES-1:0]        nxt_valid, nxt_eoe;
    logic [INT_BUSES*ADDR_W-1:0] nxt_addr;

    // Sample the routing mode only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= cfg_split ? MODE_SPLIT : MODE_SHARED;
    end

    lbd_alt u_alt (
        .clk        (clk),
        .rst_n      (rst_n),
        .split_mode (mode_q == MODE_SPLIT),
        .in_valid   (ext_valid[SPLIT_EXT]),
        .in_eoe     (ext_eoe[SPLIT_EXT]),
        .sel        (alt_sel)
    );

    lbd_route #(.ADDR_W(ADDR_W)) u_route (
        .split_mode (mode_q == MODE_SPLIT),
        .alt_sel    (alt_sel),
        .ext_valid  (ext_valid),
        .ext_eoe    (ext_eoe),
        .ext_word   (ext_word),
        .nxt_valid  (nxt_valid),
        .nxt_eoe    (nxt_eoe),
        .nxt_addr   (nxt_addr)
    );

    for (genvar k = 0; k < INT_BUSES; k++) begin : g_out
        lbd_out_reg #(.ADDR_W(ADDR_W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_valid (nxt_valid[k]),
            .d_eoe   (nxt_eoe[k]),
            .d_addr  (nxt_addr[k*ADDR_W +: ADDR_W]),
            .q_valid (int_valid[k]),
            .q_eoe   (int_eoe[k]),
            .q_addr  (int_addr[k*ADDR_W +: ADDR_W])
        );
    end
endmodule

// File: rtl/lbd_checker.sv
// Property checker for layer_bus_demux, attached with bind below.
// Assumes the fixed package layout (shared source 6, split source 0).
module lbd_checker
    import lbd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            mode_q,
    input logic [EXT_BUSES-1:0]            ext_valid,
    input logic [EXT_BUSES-1:0]            ext_eoe,
    input logic [EXT_BUSES*(ADDR_W+1)-1:0] ext_word,
    input logic [INT_BUSES-1:0]            int_valid,
    input logic [INT_BUSES-1:0]            int_eoe,
    input logic [INT_BUSES*ADDR_W-1:0]     int_addr
);
    localparam int W = ADDR_W + 1;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (int_valid == '0 && int_eoe == '0)); // R1

    AST_SHARED_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mode_q && ext_valid[6] && !ext_eoe[6]) |=>
        (int_valid[7] == $past(ext_word[6*W + ADDR_W]) && int_valid[6] == !$past(ext_word[6*W + ADDR_W]))); // R2

    AST_ADDR_STRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mode_q && ext_valid[0]) |=>
        (int_valid[0] && int_addr[ADDR_W-1:0] == $past(ext_word[ADDR_W-1:0]))); // R3

    AST_SPLIT_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_q && ext_valid[0] && !ext_eoe[0]) |=> ($countones(int_valid[1:0]) == 1)); // R4

    AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_q && ext_valid[3]) |=> int_valid[4]); // R5

    AST_EOE_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mode_q && ext_valid[6] && ext_eoe[6]) |=> (int_valid[7:6] == 2'b11 && int_eoe[7:6] == 2'b11)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ext_valid == '0) |=> (int_valid == '0)); // R7

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q)); // R8
endmodule

bind layer_bus_demux lbd_checker #(.ADDR_W(ADDR_W)) u_lbd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .ext_valid (ext_valid),
    .ext_eoe   (ext_eoe),
    .ext_word  (ext_word),
    .int_valid (int_valid),
    .int_eoe   (int_eoe),
    .int_addr  (int_addr)
);

// File: tb/test_layer_bus_demux.sv
// Bench for layer_bus_demux: directed corner cases plus seeded random traffic against a bench model.
module test_layer_bus_demux;
    localparam int AW = 12;
    localparam int W  = AW + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_split = 1'b0;
    logic [6:0]      ext_valid = '0;
    logic [6:0]      ext_eoe = '0;
    logic [W-1:0]    dw [7];
    logic [7*W-1:0]  ext_word;
    logic [7:0]      int_valid, int_eoe;
    logic [8*AW-1:0] int_addr;

    int checks = 0;
    int errs = 0;
    logic          m_mode = 1'b0;
    logic          m_tog = 1'b0;
    logic [7:0]    exp_v, exp_e;
    logic [AW-1:0] exp_a [8];

    always #4 clk = ~clk;

    always_comb
        for (int i = 0; i < 7; i++) ext_word[i*W +: W] = dw[i];

    layer_bus_demux #(.ADDR_W(AW)) i_layer_bus_demux (
        .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split),
        .ext_valid(ext_valid), .ext_eoe(ext_eoe), .ext_word(ext_word),
        .int_valid(int_valid), .int_eoe(int_eoe), .int_addr(int_addr)
    );

    task automatic put(input int k, input logic e, input logic [AW-1:0] a);
        exp_v[k] = 1'b1;
        exp_e[k] = e;
        exp_a[k] = a;
    endtask

    // Expected next outputs from the current inputs, following the requirements.
    task automatic model_step();
        exp_v = '0;
        exp_e = '0;
        for (int b = 0; b < 7; b++) begin
            if (ext_valid[b]) begin
                if (!m_mode) begin
                    if (b < 6) put(b, ext_eoe[b], dw[b][AW-1:0]);
                    else if (ext_eoe[b]) begin
                        put(6, 1'b1, dw[b][AW-1:0]);
                        put(7, 1'b1, dw[b][AW-1:0]);
                    end else put(dw[b][AW] ? 7 : 6, 1'b0, dw[b][AW-1:0]);
                end else begin
                    if (b > 0) put(b + 1, ext_eoe[b], dw[b][AW-1:0]);
                    else if (ext_eoe[b]) begin
                        put(0, 1'b1, dw[b][AW-1:0]);
                        put(1, 1'b1, dw[b][AW-1:0]);
                        m_tog = 1'b0;
                    end else begin
                        put(m_tog ? 1 : 0, 1'b0, dw[b][AW-1:0]);
                        m_tog = ~m_tog;
                    end
                end
            end
        end
    endtask

    task automatic check_out(input string tag);
        bit bad = 0;
        checks++;
        if (int_valid !== exp_v || (int_eoe & exp_v) !== exp_e) bad = 1;
        for (int k = 0; k < 8; k++)
            if (exp_v[k] && int_addr[k*AW +: AW] !== exp_a[k]) bad = 1;
        if (bad) begin
            errs++;
            $display("FAIL %s: valid=%b eoe=%b addr=%h expected valid=%b eoe=%b addr0=%h",
                     tag, int_valid, int_eoe, int_addr, exp_v, exp_e, exp_a[0]);
        end
    endtask

    task automatic idle_inputs();
        ext_valid = '0;
        ext_eoe = '0;
        for (int i = 0; i < 7; i++) dw[i] = '0;
    endtask

    // One cycle: drive at the falling edge, check just after the next rising edge.
    task automatic cycle(input string tag);
        model_step();
        @(posedge clk);
        #1;
        check_out(tag);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic one_word(input int b, input logic eoe, input logic [W-1:0] w, input string tag);
        ext_valid[b] = 1'b1;
        ext_eoe[b] = eoe;
        dw[b] = w;
        cycle(tag);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        cfg_split = mode;
        @(posedge clk);
        @(posedge clk);
        #1;
        checks++;
        if (int_valid !== 8'h00 || int_eoe !== 8'h00) begin
            errs++;
            $display("FAIL R1: valid=%b eoe=%b expected 00000000", int_valid, int_eoe);
        end
        @(negedge clk);
        rst_n = 1'b1;
        m_mode = mode;
        m_tog = 1'b0;
    endtask

    task automatic random_run(input int n, input string tag);
        for (int c = 0; c < n; c++) begin
            for (int i = 0; i < 7; i++) begin
                ext_valid[i] = ($urandom % 3) != 0;
                ext_eoe[i] = ($urandom % 8) == 0;
                dw[i] = W'($urandom);
            end
            cycle(tag);
        end
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        idle_inputs();
        // Shared-outer mode.
        do_reset(1'b0);
        one_word(6, 1'b0, {1'b0, 12'h123}, "R2");
        one_word(6, 1'b0, {1'b1, 12'h456}, "R2");
        one_word(0, 1'b0, {1'b1, 12'hABC}, "R3");
        for (int i = 0; i < 6; i++) begin
            ext_valid[i] = 1'b1;
            dw[i] = {1'b1, 12'(i * 17 + 1)};
        end
        cycle("R5");
        one_word(6, 1'b1, {1'b0, 12'h777}, "R6");
        cycle("R7");
        cfg_split = 1'b1;
        one_word(6, 1'b0, {1'b1, 12'h0F0}, "R8");
        one_word(0, 1'b0, {1'b0, 12'h00F}, "R8");
        random_run(400, "R7");
        // Inner-split mode.
        do_reset(1'b1);
        one_word(0, 1'b0, {1'b1, 12'h001}, "R4");
        one_word(0, 1'b0, {1'b0, 12'h002}, "R9");
        one_word(0, 1'b0, {1'b1, 12'h003}, "R9");
        one_word(0, 1'b1, {1'b0, 12'hEEE}, "R6");
        one_word(0, 1'b0, {1'b1, 12'h004}, "R6");
        for (int i = 1; i < 7; i++) begin
            ext_valid[i] = 1'b1;
            dw[i] = {1'b0, 12'(i * 33)};
        end
        cycle("R5");
        random_run(400, "R4");
        // Alternation restarts at the lower bus after a reset mid-stream.
        one_word(0, 1'b0, {1'b0, 12'h010}, "R4");
        do_reset(1'b1);
        one_word(0, 1'b0, {1'b0, 12'h011}, "R1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule